// File: doc/BRIEF.md
# Abstract Register Access Command Unit

This unit sits between a debugger-facing register bus and a halted hart. The debugger writes a 32-bit command word. The unit decodes it, checks it against what it supports, and then runs up to two steps in order. The first is a register transfer over a request/acknowledge port to the hart's register file. The second is a single run of the program buffer, started with a one-cycle trigger and finished by a done pulse.

A single 32-bit data word carries values in both directions between the debugger and the hart. A control/status word reports a busy flag, a 3-bit sticky error code and two fixed capacity counts. While the error code is non-zero the unit takes no new command. The debugger clears the code by writing ones to it, bit by bit.

Bus map: 0x04 is the data word, 0x16 is control/status and 0x17 is the command. Reads are combinational from the address. Any other address reads as zero.

Top module: `abstract_cmd_unit`

## Requirements
- R1: After reset, busy and the error code are 0 and the data word is 0. The status word at 0x16 holds PROG_WORDS in bits 28:24, busy in bit 12, the error code in bits 10:8 and DATA_WORDS in bits 3:0. All other bits of the status word read 0.
- R2: The command type sits in bits 31:24. Any non-zero type is rejected with error code 2 and starts nothing.
- R3: When the transfer bit (17) is set, the size field (bits 22:20) must be 2. The register number (bits 15:0) must also be below 0x1040: 0x0000–0x0FFF are CSRs, 0x1000–0x101F are integer registers and 0x1020–0x103F are floating-point registers. Any other value gives error code 2. When bit 17 is clear, size and register number are not checked and no hart request is issued.
- R4: A transfer with direction bit 16 at 0 raises regReq with regWrite=0. The register number and size stay stable until regAck. The acknowledged regRdata is then stored in the data word.
- R5: A transfer with bit 16 at 1 presents the data word on regWdata with regWrite=1. The data word itself does not change.
- R6: With bit 18 set, progExec pulses for exactly one cycle. The pulse comes after the transfer succeeds, or at once when there is no transfer. Busy then stays high until progDone.
- R7: With bit 19 set, a successful transfer adds one to the register number held in the command word. The updated value reads back at 0x17.
- R8: A regAck with regExc, or a progDone with progExc, sets error code 3. After a faulting transfer there is no program run and no increment, and the data word keeps its value.
- R9: A valid command issued while hartHalted is 0 sets error code 4 and issues no request.
- R10: While the error code is non-zero, command writes are ignored: no request, no trigger and no change to the word read at 0x17. Writing the status word clears each error bit written as 1 and leaves the others.
- R11: While busy, a write to the command or data word changes neither word and sets error code 1.
- R12: If a debugger write to the data word and the hart's acknowledge of a register read land on the same edge, the hart value is stored and error code 1 is set. If that acknowledge carries an exception, code 3 is set instead.
- R13: Address 0x17 reads back the last accepted command word, including any increment. 0x04 reads the data word. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Debugger write strobe |
| busAddr | input | 7 | Debugger word address |
| busWdata | input | 32 | Debugger write data |
| busRdata | output | 32 | Debugger read data, combinational from busAddr |
| hartHalted | input | 1 | Hart is halted and able to serve requests |
| regReq | output | 1 | Register access request, held until regAck |
| regWrite | output | 1 | 1: write regWdata into the register; 0: read it |
| regNum | output | 16 | Register number |
| regSize | output | 3 | Access size code |
| regWdata | output | 32 | Value for a register write |
| regAck | input | 1 | Register access completed |
| regExc | input | 1 | Completed access raised an exception |
| regRdata | input | 32 | Value read from the register |
| progExec | output | 1 | One-cycle pulse: run the program buffer once |
| progDone | input | 1 | Program buffer run finished |
| progExc | input | 1 | Program buffer run raised an exception |

## Verification
The one overlap that is hard to reach is between the hart finishing a register read and the debugger writing the data word. Both try to load the same register on one edge, and both may also want to set the error code. The bench sets the hart's reply latency to a known number of cycles and times a data-word write so that it lands on the acknowledge edge. It then reads back the data word and the error code. The hart value must win and code 1 must be reported. In a second run the acknowledge carries an exception, and code 3 must win while the data word stays unchanged.

// File: rtl/absc_pkg.sv
package absc_pkg;

  localparam logic [6:0] ADDR_DATA0  = 7'h04;
  localparam logic [6:0] ADDR_STATUS = 7'h16;
  localparam logic [6:0] ADDR_CMD    = 7'h17;

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BUSY   = 3'd1;
  localparam logic [2:0] ERR_UNSUP  = 3'd2;
  localparam logic [2:0] ERR_EXCEPT = 3'd3;
  localparam logic [2:0] ERR_HALT   = 3'd4;

  localparam logic [2:0] SIZE_WORD = 3'd2;

  // command word field positions
  localparam int CMD_TYPE_LO = 24;
  localparam int CMD_SIZE_LO = 20;
  localparam int CMD_INC_BIT = 19;
  localparam int CMD_EXEC_BIT = 18;
  localparam int CMD_XFER_BIT = 17;
  localparam int CMD_WR_BIT = 16;

  // status word field positions
  localparam int ST_PROG_LO = 24;
  localparam int ST_BUSY_BIT = 12;
  localparam int ST_ERR_LO = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_PROG,
    ST_PWAIT
  } absc_state_e;

  typedef struct packed {
    logic loadCmd;
    logic busData0;
    logic hartData0;
    logic incRegno;
  } absc_strobe_t;

endpackage

// File: rtl/absc_ctrl.sv
module absc_ctrl
  import absc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BUS_W = 32,
  parameter bit HAS_FP = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  input  logic               hartHalted,
  input  logic               regAck,
  input  logic               regExc,
  input  logic               progDone,
  input  logic               progExc,
  input  logic [BUS_W-1:0]   cmdQ,
  output absc_strobe_t       strobe,
  output logic               busy,
  output logic [2:0]         cmdErr,
  output logic               regReq,
  output logic               progExec
);

  localparam logic [15:0] RegLimit = HAS_FP ? 16'h1040 : 16'h1020;

  absc_state_e state, stateNext;
  logic [2:0] errNext;

  logic cmdWr, dataWr, statWr;
  logic newXfer, newExec, typeBad, sizeBad, regBad, unsupported, accept;
  logic xferDone, progFin, hartFault;

  assign cmdWr  = busWe && (busAddr == ADDR_CMD);
  assign dataWr = busWe && (busAddr == ADDR_DATA0);
  assign statWr = busWe && (busAddr == ADDR_STATUS);

  assign newXfer = busWdata[CMD_XFER_BIT];
  assign newExec = busWdata[CMD_EXEC_BIT];
  assign typeBad = busWdata[BUS_W-1:CMD_TYPE_LO] != '0;
  assign sizeBad = busWdata[CMD_SIZE_LO+2:CMD_SIZE_LO] != SIZE_WORD;
  assign regBad  = busWdata[15:0] >= RegLimit;
  assign unsupported = typeBad || (newXfer && (sizeBad || regBad));

  assign busy = (state != ST_IDLE);
  assign accept = cmdWr && !busy && (cmdErr == ERR_NONE) && !unsupported && hartHalted;

  assign xferDone = (state == ST_XFER) && regAck;
  assign progFin  = (state == ST_PWAIT) && progDone;
  assign hartFault = (xferDone && regExc) || (progFin && progExc);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (newXfer) stateNext = ST_XFER;
          else if (newExec) stateNext = ST_PROG;
        end
      end
      ST_XFER: begin
        if (regAck) begin
          if (!regExc && cmdQ[CMD_EXEC_BIT]) stateNext = ST_PROG;
          else stateNext = ST_IDLE;
        end
      end
      ST_PROG:  stateNext = ST_PWAIT;
      ST_PWAIT: if (progDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    errNext = cmdErr;
    if (statWr) errNext = cmdErr & ~busWdata[ST_ERR_LO+2:ST_ERR_LO];
    if (cmdErr == ERR_NONE) begin
      if (hartFault) errNext = ERR_EXCEPT;
      else if (busy && (cmdWr || dataWr)) errNext = ERR_BUSY;
      else if (cmdWr && unsupported) errNext = ERR_UNSUP;
      else if (cmdWr && !hartHalted) errNext = ERR_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cmdErr <= ERR_NONE;
    end else begin
      state  <= stateNext;
      cmdErr <= errNext;
    end
  end

  always_comb begin
    strobe.loadCmd   = accept;
    strobe.busData0  = dataWr && !busy;
    strobe.hartData0 = xferDone && !regExc && !cmdQ[CMD_WR_BIT];
    strobe.incRegno  = xferDone && !regExc && cmdQ[CMD_INC_BIT];
  end

  assign regReq   = (state == ST_XFER);
  assign progExec = (state == ST_PROG);

endmodule

// File: rtl/absc_dpath.sv
module absc_dpath
  import absc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BUS_W = 32,
  parameter int PROG_WORDS = 8,
  parameter int DATA_WORDS = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  absc_strobe_t       strobe,
  input  logic               busy,
  input  logic [2:0]         cmdErr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  input  logic [BUS_W-1:0]   regRdata,
  output logic [BUS_W-1:0]   busRdata,
  output logic [BUS_W-1:0]   cmdQ,
  output logic [BUS_W-1:0]   data0Q
);

  localparam logic [4:0] ProgField = 5'(PROG_WORDS);
  localparam logic [3:0] DataField = 4'(DATA_WORDS);

  logic [BUS_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= '0;
      data0Q <= '0;
    end else begin
      if (strobe.loadCmd) cmdQ <= busWdata;
      else if (strobe.incRegno) cmdQ[15:0] <= cmdQ[15:0] + 16'd1;
      if (strobe.hartData0) data0Q <= regRdata;
      else if (strobe.busData0) data0Q <= busWdata;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ST_PROG_LO+4:ST_PROG_LO] = ProgField;
    statusWord[ST_BUSY_BIT] = busy;
    statusWord[ST_ERR_LO+2:ST_ERR_LO] = cmdErr;
    statusWord[3:0] = DataField;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_DATA0:  busRdata = data0Q;
      ADDR_STATUS: busRdata = statusWord;
      ADDR_CMD:    busRdata = cmdQ;
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/abstract_cmd_unit.sv
module abstract_cmd_unit
  import absc_pkg::*;
#(
  parameter int PROG_WORDS = 8,
  parameter int DATA_WORDS = 1,
  parameter bit HAS_FP = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [6:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        hartHalted,
  output logic        regReq,
  output logic        regWrite,
  output logic [15:0] regNum,
  output logic [2:0]  regSize,
  output logic [31:0] regWdata,
  input  logic        regAck,
  input  logic        regExc,
  input  logic [31:0] regRdata,
  output logic        progExec,
  input  logic        progDone,
  input  logic        progExc
);

  localparam int AddrW = 7;
  localparam int BusW = 32;

  absc_strobe_t strobe;
  logic busy;
  logic [2:0] cmdErr;
  logic [BusW-1:0] cmdQ, data0Q;

  absc_ctrl #(.ADDR_W(AddrW), .BUS_W(BusW), .HAS_FP(HAS_FP)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .hartHalted(hartHalted), .regAck(regAck), .regExc(regExc),
    .progDone(progDone), .progExc(progExc), .cmdQ(cmdQ),
    .strobe(strobe), .busy(busy), .cmdErr(cmdErr),
    .regReq(regReq), .progExec(progExec)
  );

  absc_dpath #(.ADDR_W(AddrW), .BUS_W(BusW), .PROG_WORDS(PROG_WORDS),
               .DATA_WORDS(DATA_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .cmdErr(cmdErr),
    .busAddr(busAddr), .busWdata(busWdata), .regRdata(regRdata),
    .busRdata(busRdata), .cmdQ(cmdQ), .data0Q(data0Q)
  );

  assign regWrite = cmdQ[CMD_WR_BIT];
  assign regNum   = cmdQ[15:0];
  assign regSize  = cmdQ[CMD_SIZE_LO+2:CMD_SIZE_LO];
  assign regWdata = data0Q;

endmodule

// File: rtl/absc_checker.sv
module absc_checker
  import absc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWe,
  input logic [6:0]  busAddr,
  input logic        hartHalted,
  input logic        regReq,
  input logic        regWrite,
  input logic [15:0] regNum,
  input logic        regAck,
  input logic        regExc,
  input logic        progExec,
  input logic        busy,
  input logic [2:0]  cmdErr,
  input logic [31:0] data0Q
);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regNum) && $stable(regWrite)));

  assert_exec_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    progExec |=> !progExec);

  assert_start_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regReq) |-> $past(hartHalted));

  assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CMD && cmdErr != ERR_NONE && !busy) |=> (!regReq && !progExec));

  assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regAck && regExc && cmdErr == ERR_NONE) |=> (cmdErr == ERR_EXCEPT));

  assert_busy_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_DATA0 && busy && !(regReq && regAck)) |=> $stable(data0Q));

endmodule

bind abstract_cmd_unit absc_checker u_absc_checker (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .hartHalted(hartHalted),
  .regReq(regReq), .regWrite(regWrite), .regNum(regNum), .regAck(regAck), .regExc(regExc),
  .progExec(progExec), .busy(busy), .cmdErr(cmdErr), .data0Q(data0Q)
);

// File: tb/tb_abstract_cmd_unit.sv
module tb_abstract_cmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int DW = 1;
  localparam logic [6:0] A_DATA = 7'h04, A_STAT = 7'h16, A_CMD = 7'h17;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWe = 1'b0;
  logic [6:0] busAddr = 7'h00;
  logic [31:0] busWdata = '0, busRdata;
  logic hartHalted = 1'b1;
  logic regReq, regWrite, regAck = 1'b0, regExc = 1'b0;
  logic [15:0] regNum;
  logic [2:0] regSize;
  logic [31:0] regWdata, regRdata = '0;
  logic progExec, progDone = 1'b0, progExc = 1'b0;

  int checks = 0, errors = 0;
  int hartLat = 0, progLat = 0, reqCount = 0, progCount = 0;
  logic [15:0] excNum = 16'hFFFF;
  logic progFault = 1'b0;
  logic [15:0] lastNum = '0;
  logic [31:0] lastData = '0;
  int hCnt = 0, pCnt = 0;
  logic pBusy = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abstract_cmd_unit #(.PROG_WORDS(PW), .DATA_WORDS(DW), .HAS_FP(1'b1)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .hartHalted(hartHalted), .regReq(regReq), .regWrite(regWrite),
    .regNum(regNum), .regSize(regSize), .regWdata(regWdata), .regAck(regAck),
    .regExc(regExc), .regRdata(regRdata), .progExec(progExec), .progDone(progDone),
    .progExc(progExc)
  );

  function automatic logic [31:0] hartVal(logic [15:0] n);
    return {16'hC0DE ^ n, n};
  endfunction

  function automatic logic [31:0] mkCmd(int t, int sz, bit inc, bit ex, bit xf, bit wr,
                                        logic [15:0] r);
    return {8'(t), 1'b0, 3'(sz), inc, ex, xf, wr, r};
  endfunction

  // hart register-file model
  always @(negedge clk) begin
    regAck <= 1'b0;
    if (regReq && !regAck) begin
      if (hCnt == hartLat) begin
        regAck <= 1'b1;
        regExc <= (regNum == excNum);
        regRdata <= hartVal(regNum);
        reqCount <= reqCount + 1;
        if (regWrite) begin
          lastNum <= regNum;
          lastData <= regWdata;
        end
        hCnt <= 0;
      end else hCnt <= hCnt + 1;
    end
  end

  // program buffer model
  always @(negedge clk) begin
    progDone <= 1'b0;
    if (progExec) begin
      progCount <= progCount + 1;
      pCnt <= progLat;
      pBusy <= 1'b1;
    end else if (pBusy) begin
      if (pCnt == 0) begin
        progDone <= 1'b1;
        progExc <= progFault;
        pBusy <= 1'b0;
      end else pCnt <= pCnt - 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      busRead(A_STAT, s);
      if (!s[12]) break;
    end
  endtask

  task automatic runCmd(logic [31:0] c);
    busWrite(A_CMD, c);
    waitIdle();
  endtask

  task automatic errIs(string req, logic [2:0] e);
    logic [31:0] s;
    busRead(A_STAT, s);
    chk(req, {29'b0, s[10:8]}, {29'b0, e});
  endtask

  task automatic clrErr();
    busWrite(A_STAT, 32'h0000_0700);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] regList [10];
    int r0, p0;
    regList = '{16'h0000, 16'h0FFF, 16'h1000, 16'h101F, 16'h1020, 16'h103F,
                16'h1040, 16'hBFFF, 16'hC000, 16'hFFFF};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and status layout
    busRead(A_STAT, v);
    chk("R1 status", v, (32'(PW) << 24) | 32'(DW));
    busRead(A_DATA, v);
    chk("R1 data0", v, 32'h0);
    chk("R1 regReq", {31'b0, regReq}, 32'h0);
    busRead(7'h33, v);
    chk("R13 unmapped", v, 32'h0);

    // R2: command type sweep
    for (int t = 0; t < 8; t++) begin
      r0 = reqCount;
      runCmd(mkCmd(t * 37, 2, 0, 0, 1, 0, 16'h1001));
      errIs("R2 type err", (t == 0) ? 3'd0 : 3'd2);
      chk("R2 req count", 32'(reqCount - r0), (t == 0) ? 32'd1 : 32'd0);
      clrErr();
    end

    // R3: size sweep
    for (int sz = 0; sz < 8; sz++) begin
      runCmd(mkCmd(0, sz, 0, 0, 1, 0, 16'h1002));
      errIs("R3 size err", (sz == 2) ? 3'd0 : 3'd2);
      clrErr();
    end

    // R3, R4: register number ranges with reads
    foreach (regList[i]) begin
      r0 = reqCount;
      busWrite(A_DATA, 32'h1111_0000 + 32'(i));
      runCmd(mkCmd(0, 2, 0, 0, 1, 0, regList[i]));
      errIs("R3 regno err", (regList[i] < 16'h1040) ? 3'd0 : 3'd2);
      busRead(A_DATA, v);
      chk("R4 data0 read", v, (regList[i] < 16'h1040) ? hartVal(regList[i])
                                                       : 32'h1111_0000 + 32'(i));
      clrErr();
      // transfer off: size/regno ignored, no request
      r0 = reqCount;
      runCmd(mkCmd(0, 7, 0, 0, 0, 0, regList[i]));
      errIs("R3 no-xfer ignored", 3'd0);
      chk("R3 no-xfer req", 32'(reqCount - r0), 32'd0);
    end

    // R5, R6, R7: all combinations of inc/exec/xfer/write
    for (int k = 0; k < 16; k++) begin
      bit inc, ex, xf, wr;
      logic [31:0] d;
      {inc, ex, xf, wr} = 4'(k);
      d = 32'h1234_0000 + 32'(k);
      hartLat = k % 3;
      progLat = k % 4;
      busWrite(A_DATA, d);
      r0 = reqCount; p0 = progCount;
      runCmd(mkCmd(0, 2, inc, ex, xf, wr, 16'h1010));
      errIs("R6 combo err", 3'd0);
      chk("R6 prog count", 32'(progCount - p0), ex ? 32'd1 : 32'd0);
      chk("R4 req count", 32'(reqCount - r0), xf ? 32'd1 : 32'd0);
      busRead(A_DATA, v);
      chk("R5 data0", v, (xf && !wr) ? hartVal(16'h1010) : d);
      if (xf && wr) begin
        chk("R5 hart num", {16'b0, lastNum}, 32'h1010);
        chk("R5 hart data", lastData, d);
      end
      busRead(A_CMD, v);
      chk("R7 regno readback", {16'b0, v[15:0]}, (xf && inc) ? 32'h1011 : 32'h1010);
    end
    hartLat = 0; progLat = 0;

    // R7: increment across the GPR/FPR boundary, R13 full readback
    runCmd(mkCmd(0, 2, 1, 0, 1, 0, 16'h101F));
    busRead(A_CMD, v);
    chk("R13 cmd readback", v, mkCmd(0, 2, 1, 0, 1, 0, 16'h1020));

    // R8: hart exception on transfer
    excNum = 16'h1005;
    busWrite(A_DATA, 32'hAAAA_0001);
    p0 = progCount;
    runCmd(mkCmd(0, 2, 1, 1, 1, 0, 16'h1005));
    errIs("R8 exc err", 3'd3);
    chk("R8 no prog", 32'(progCount - p0), 32'd0);
    busRead(A_DATA, v);
    chk("R8 data0 kept", v, 32'hAAAA_0001);
    busRead(A_CMD, v);
    chk("R8 no inc", {16'b0, v[15:0]}, 32'h1005);

    // R10: error blocks commands; per-bit clear
    r0 = reqCount;
    runCmd(mkCmd(0, 2, 0, 0, 1, 0, 16'h1001));
    chk("R10 blocked req", 32'(reqCount - r0), 32'd0);
    busRead(A_CMD, v);
    chk("R10 cmd unchanged", {16'b0, v[15:0]}, 32'h1005);
    busWrite(A_STAT, 32'h0000_0100);
    errIs("R10 partial clear", 3'd2);
    clrErr();
    errIs("R10 full clear", 3'd0);
    excNum = 16'hFFFF;

    // R8: program buffer exception
    progFault = 1'b1;
    runCmd(mkCmd(0, 0, 0, 1, 0, 0, 16'h0));
    errIs("R8 prog exc", 3'd3);
    clrErr();
    progFault = 1'b0;

    // R9: not halted
    hartHalted = 1'b0;
    r0 = reqCount;
    runCmd(mkCmd(0, 2, 0, 0, 1, 0, 16'h1003));
    errIs("R9 halt err", 3'd4);
    chk("R9 no req", 32'(reqCount - r0), 32'd0);
    clrErr();
    hartHalted = 1'b1;

    // R11: writes while busy
    hartLat = 6;
    busWrite(A_CMD, mkCmd(0, 2, 0, 0, 1, 0, 16'h1007));
    busWrite(A_DATA, 32'hBEEF_0000);
    busWrite(A_CMD, mkCmd(0, 2, 0, 0, 1, 0, 16'h1008));
    waitIdle();
    errIs("R11 busy err", 3'd1);
    busRead(A_DATA, v);
    chk("R11 data0", v, hartVal(16'h1007));
    busRead(A_CMD, v);
    chk("R11 cmd kept", {16'b0, v[15:0]}, 32'h1007);
    clrErr();

    // R12: data0 write on the acknowledge edge
    hartLat = 3;
    busWrite(A_CMD, mkCmd(0, 2, 0, 0, 1, 0, 16'h1001));
    repeat (2) @(negedge clk);
    busWrite(A_DATA, 32'hDEAD_0001);
    waitIdle();
    errIs("R12 same-cycle err", 3'd1);
    busRead(A_DATA, v);
    chk("R12 hart wins", v, hartVal(16'h1001));
    clrErr();

    excNum = 16'h1002;
    busWrite(A_CMD, mkCmd(0, 2, 0, 0, 1, 0, 16'h1002));
    repeat (2) @(negedge clk);
    busWrite(A_DATA, 32'hDEAD_0002);
    waitIdle();
    errIs("R12 exc wins", 3'd3);
    busRead(A_DATA, v);
    chk("R12 data0 kept", v, hartVal(16'h1001));
    clrErr();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule